// File: doc/BRIEF.md
# Banked RAM Expansion Controller

This block is the decode and steering logic for a 512 KB banked RAM expansion on an 8-bit computer with a Z80-style bus. It watches the host's I/O writes for a memory-configuration byte and keeps a 3-bit segment number and a 3-bit banking mode. On every memory cycle it decides whether the access belongs to the host's internal RAM or to the expansion array. For an expansion access it forms the 19-bit expansion address and drives the array's chip select and write enable.

The host's read-disable line only keeps internal RAM off the data bus during reads. Writes would still land in internal RAM as well. So, for every write sent to the expansion, the block also holds the host's memory request inactive, and the host's memory controller then drops the write.

Banking mode 3 sends the 0x4000 window to the internal top page. A static switch picks how this is done. In normal mode the block forces A15 high toward internal RAM. In shadow mode internal RAM is switched off entirely, and a reserved 64 KB expansion segment stands in for base memory.

Top module: `bxr_top`

## Requirements
- R1: After a synchronous reset the configuration is mode 0, segment 0. In normal mode every memory access then stays internal: xram_cs, xram_we, int_rd_dis, mreq_block and a15_force are all low.
- R2: A configuration write is recognised on a cycle with iorq and wr high, addr[15:14] = 01 and data[7:6] = 11. On that clock edge the segment is loaded from data[5:3] and the mode from data[2:0]. The new configuration governs accesses from the next cycle onward.
- R3: An I/O write that fails either the port match (addr[15:14] ≠ 01) or the data prefix (data[7:6] ≠ 11) leaves the configuration unchanged.
- R4: For every expansion access, xram_addr = {segment, page, addr[13:0]}. The segment sits in bits 18:16 and the page in bits 15:14. Outside expansion accesses xram_addr is zero.
- R5: Windows are addr[15:14] = 0..3. The mode map is:
  - Mode 0: all windows internal.
  - Mode 1: window 3 uses expansion page 3.
  - Mode 2: window w uses expansion page w.
  - Modes 4–7: window 1 uses expansion page (mode−4).
  - Any window not listed for a mode is internal.
- R6: In mode 3 with the switch in normal mode:
  - Window 3 uses expansion page 3.
  - Window 1 is internal with a15_force high.
  - Windows 0 and 2 are internal.
  - a15_force is low in every other case.
- R7: A read routed to the expansion drives xram_cs and int_rd_dis high and xram_we and mreq_block low.
- R8: A write routed to the expansion drives xram_cs, xram_we, int_rd_dis and mreq_block all high.
- R9: An internal access drives xram_cs, xram_we, int_rd_dis and mreq_block low.
- R10: With shadow_sw high, every memory access goes to the expansion and a15_force stays low. Windows that a mode leaves internal map to segment 7, page = window number; in mode 3, window 1 instead maps to segment 7, page 3.
- R11: While mreq is low, or neither rd nor wr is high, all six outputs are zero.
- R12: Two configurations that differ only in the segment field, such as 0xC3 and 0xD3, place window 3 in different 64 KB segments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shadow_sw | input | 1 | Static switch: 1 = shadow mode, 0 = normal mode |
| mreq | input | 1 | Host memory request, active high |
| iorq | input | 1 | Host I/O request, active high |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| addr | input | 16 | Host address bus |
| data | input | 8 | Host data bus (used for configuration writes) |
| xram_addr | output | 19 | Expansion RAM address |
| xram_cs | output | 1 | Expansion RAM chip select |
| xram_we | output | 1 | Expansion RAM write enable |
| int_rd_dis | output | 1 | Keeps internal RAM off the data bus |
| mreq_block | output | 1 | Holds the host memory request inactive toward internal RAM |
| a15_force | output | 1 | Forces A15 high toward internal RAM |

## Verification
The assertions check on every cycle that outputs stay quiet without a memory request and that any expansion write also blocks the memory request. They also check that a15_force never coincides with an expansion select, that shadow mode always selects the expansion, and that configuration writes are captured or ignored as required. Only the bench's scenarios can show that the full mode, segment, window and direction table produces the right addresses. This covers the segment field telling 0xC3 apart from 0xD3, and the shadow remapping of internal windows. The bench sweeps that table exhaustively in both switch positions and then runs a random mix of valid, mis-addressed and malformed configuration writes between memory cycles.

// File: rtl/bxr_pkg.sv
package bxr_pkg;
  localparam int WIN_W  = 2;
  localparam int PAGE_W = 2;
  localparam int NWIN   = 1 << WIN_W;

  typedef struct packed {
    logic              to_exp;
    logic              redirect;
    logic [PAGE_W-1:0] page;
  } win_map_t;
endpackage

// File: rtl/bxr_cfg_reg.sv
module bxr_cfg_reg #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int SEG_W  = 3,
  parameter int MODE_W = 3,
  parameter logic [ADDR_W-1:0] PORT_MASK  = 16'hC000,
  parameter logic [ADDR_W-1:0] PORT_MATCH = 16'h4000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iorq,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic [SEG_W-1:0]  seg_q,
  output logic [MODE_W-1:0] mode_q
);
  localparam int TAG_W = DATA_W - SEG_W - MODE_W;

  logic port_hit, tag_ok, load;

  assign port_hit = ((addr & PORT_MASK) == PORT_MATCH);
  assign tag_ok   = (data[DATA_W-1 -: TAG_W] == {TAG_W{1'b1}});
  assign load     = iorq && wr && port_hit && tag_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q  <= '0;
      mode_q <= '0;
    end else if (load) begin
      seg_q  <= data[MODE_W +: SEG_W];
      mode_q <= data[0 +: MODE_W];
    end
  end

  // R2: accepted byte lands in the register on the next edge
  a_r2_cfg_capture: assert property (@(posedge clk) disable iff (rst)
    load |=> (seg_q == $past(data[MODE_W +: SEG_W])) && (mode_q == $past(data[0 +: MODE_W])));

  // R3: any other I/O write leaves the configuration alone
  a_r3_cfg_hold: assert property (@(posedge clk) disable iff (rst)
    (iorq && wr && !(port_hit && tag_ok)) |=> ($stable(seg_q) && $stable(mode_q)));
endmodule

// File: rtl/bxr_win_map.sv
module bxr_win_map #(
  parameter int MODE_W = 3
) (
  input  logic [MODE_W-1:0]          mode,
  input  logic [bxr_pkg::WIN_W-1:0]  window,
  output bxr_pkg::win_map_t          sel
);
  import bxr_pkg::*;

  win_map_t per_win [NWIN];

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    always_comb begin
      per_win[w] = '0;
      if (mode[MODE_W-1]) begin
        if (w == 1) begin
          per_win[w].to_exp = 1'b1;
          per_win[w].page   = mode[PAGE_W-1:0];
        end
      end else begin
        unique case (mode[1:0])
          2'd0: ;
          2'd1: if (w == NWIN-1) begin
                  per_win[w].to_exp = 1'b1;
                  per_win[w].page   = PAGE_W'(NWIN-1);
                end
          2'd2: begin
                  per_win[w].to_exp = 1'b1;
                  per_win[w].page   = PAGE_W'(w);
                end
          2'd3: if (w == NWIN-1) begin
                  per_win[w].to_exp = 1'b1;
                  per_win[w].page   = PAGE_W'(NWIN-1);
                end else if (w == 1) begin
                  per_win[w].redirect = 1'b1;
                  per_win[w].page     = PAGE_W'(NWIN-1);
                end
          default: ;
        endcase
      end
    end
  end

  assign sel = per_win[window];
endmodule

// File: rtl/bxr_route.sv
module bxr_route #(
  parameter int SEG_W      = 3,
  parameter int OFS_W      = 14,
  parameter int SHADOW_SEG = 7,
  parameter int XADDR_W    = SEG_W + bxr_pkg::PAGE_W + OFS_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       shadow_sw,
  input  logic                       mreq,
  input  logic                       rd,
  input  logic                       wr,
  input  logic [bxr_pkg::WIN_W-1:0]  window,
  input  logic [OFS_W-1:0]           offset,
  input  logic [SEG_W-1:0]           seg,
  input  bxr_pkg::win_map_t          sel,
  output logic [XADDR_W-1:0]         xram_addr,
  output logic                       xram_cs,
  output logic                       xram_we,
  output logic                       int_rd_dis,
  output logic                       mreq_block,
  output logic                       a15_force
);
  import bxr_pkg::*;

  logic              mem_cyc, go_exp;
  logic [SEG_W-1:0]  x_seg;
  logic [PAGE_W-1:0] x_page;

  assign mem_cyc = mreq && (rd || wr);
  assign go_exp  = mem_cyc && (shadow_sw || sel.to_exp);

  always_comb begin
    if (sel.to_exp) begin
      x_seg  = seg;
      x_page = sel.page;
    end else begin
      x_seg  = SEG_W'(SHADOW_SEG);
      x_page = sel.redirect ? sel.page : PAGE_W'(window);
    end
  end

  assign xram_addr  = go_exp ? {x_seg, x_page, offset} : '0;
  assign xram_cs    = go_exp;
  assign xram_we    = go_exp && wr;
  assign int_rd_dis = go_exp;
  assign mreq_block = go_exp && wr;
  assign a15_force  = mem_cyc && !shadow_sw && sel.redirect;

  // R8: an expansion write must also keep internal RAM from taking it
  a_r8_write_blocked: assert property (@(posedge clk) disable iff (rst)
    xram_we |-> (mreq_block && int_rd_dis && xram_cs));

  // R11: nothing is driven outside a memory cycle
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !(mreq && (rd || wr)) |-> !(xram_cs || xram_we || int_rd_dis || mreq_block || a15_force));

  // R10: shadow mode routes every memory cycle to the expansion
  a_r10_shadow_all_exp: assert property (@(posedge clk) disable iff (rst)
    (shadow_sw && mreq && (rd || wr)) |-> (xram_cs && !a15_force));

  // R6: the A15 redirect only ever goes to internal RAM
  a_r6_a15_internal: assert property (@(posedge clk) disable iff (rst)
    a15_force |-> (!xram_cs && !mreq_block && window == WIN_W'(1)));

  // R7: expansion reads never assert write enable
  a_r7_read_no_we: assert property (@(posedge clk) disable iff (rst)
    (xram_cs && !wr) |-> (!xram_we && !mreq_block && int_rd_dis));
endmodule

// File: rtl/bxr_top.sv
module bxr_top #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int SEG_W      = 3,
  parameter int MODE_W     = 3,
  parameter int SHADOW_SEG = 7,
  parameter logic [ADDR_W-1:0] PORT_MASK  = 16'hC000,
  parameter logic [ADDR_W-1:0] PORT_MATCH = 16'h4000,
  localparam int OFS_W   = ADDR_W - bxr_pkg::WIN_W,
  localparam int XADDR_W = SEG_W + bxr_pkg::PAGE_W + OFS_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               shadow_sw,
  input  logic               mreq,
  input  logic               iorq,
  input  logic               rd,
  input  logic               wr,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  data,
  output logic [XADDR_W-1:0] xram_addr,
  output logic               xram_cs,
  output logic               xram_we,
  output logic               int_rd_dis,
  output logic               mreq_block,
  output logic               a15_force
);
  import bxr_pkg::*;

  logic [SEG_W-1:0]  seg_q;
  logic [MODE_W-1:0] mode_q;
  logic [WIN_W-1:0]  window;
  win_map_t          sel;

  assign window = addr[ADDR_W-1 -: WIN_W];

  bxr_cfg_reg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEG_W(SEG_W), .MODE_W(MODE_W),
    .PORT_MASK(PORT_MASK), .PORT_MATCH(PORT_MATCH)
  ) u_cfg (
    .clk(clk), .rst(rst), .iorq(iorq), .wr(wr), .addr(addr), .data(data),
    .seg_q(seg_q), .mode_q(mode_q)
  );

  bxr_win_map #(.MODE_W(MODE_W)) u_map (
    .mode(mode_q), .window(window), .sel(sel)
  );

  bxr_route #(
    .SEG_W(SEG_W), .OFS_W(OFS_W), .SHADOW_SEG(SHADOW_SEG)
  ) u_route (
    .clk(clk), .rst(rst), .shadow_sw(shadow_sw), .mreq(mreq), .rd(rd), .wr(wr),
    .window(window), .offset(addr[OFS_W-1:0]), .seg(seg_q), .sel(sel),
    .xram_addr(xram_addr), .xram_cs(xram_cs), .xram_we(xram_we),
    .int_rd_dis(int_rd_dis), .mreq_block(mreq_block), .a15_force(a15_force)
  );

  // R5: mode 0 in normal mode never touches the expansion
  a_r5_mode0_internal: assert property (@(posedge clk) disable iff (rst)
    (mode_q == '0 && !shadow_sw) |-> (!xram_cs && !a15_force));

  // R12: the expansion segment bits follow the latched segment field
  a_r12_seg_follows: assert property (@(posedge clk) disable iff (rst)
    (xram_cs && !shadow_sw) |-> (xram_addr[XADDR_W-1 -: SEG_W] == seg_q));
endmodule

// File: tb/tb_bxr_top.sv
module tb_bxr_top;
  logic        clk = 1'b0;
  logic        rst, shadow_sw, mreq, iorq, rd, wr;
  logic [15:0] addr;
  logic [7:0]  data;
  logic [18:0] xram_addr;
  logic        xram_cs, xram_we, int_rd_dis, mreq_block, a15_force;

  int n_chk = 0, n_fail = 0;
  logic [2:0] m_seg, m_mode;

  always #10 clk = ~clk;

  bxr_top dut (
    .clk(clk), .rst(rst), .shadow_sw(shadow_sw), .mreq(mreq), .iorq(iorq),
    .rd(rd), .wr(wr), .addr(addr), .data(data), .xram_addr(xram_addr),
    .xram_cs(xram_cs), .xram_we(xram_we), .int_rd_dis(int_rd_dis),
    .mreq_block(mreq_block), .a15_force(a15_force)
  );

  initial begin
    #4000000;
    n_fail++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  // expected {xaddr[18:0], cs, we, rddis, mblk, a15}
  function automatic logic [23:0] expect_out(input logic [2:0] mode, input logic [2:0] seg,
      input logic sh, input logic mq, input logic r, input logic w, input logic [15:0] a);
    logic [1:0] win;
    logic ex, redir;
    logic [1:0] pg;
    logic go;
    logic [18:0] xa;
    win = a[15:14];
    ex = 1'b0; redir = 1'b0; pg = 2'd0;
    case (mode)
      3'd1: if (win == 2'd3) begin ex = 1'b1; pg = 2'd3; end
      3'd2: begin ex = 1'b1; pg = win; end
      3'd3: if (win == 2'd3) begin ex = 1'b1; pg = 2'd3; end
            else if (win == 2'd1) redir = 1'b1;
      3'd4, 3'd5, 3'd6, 3'd7: if (win == 2'd1) begin ex = 1'b1; pg = mode[1:0]; end
      default: ;
    endcase
    if (!(mq && (r || w))) return '0;
    go = sh || ex;
    if (ex) xa = {seg, pg, a[13:0]};
    else    xa = {3'd7, (redir ? 2'd3 : win), a[13:0]};
    if (!go) xa = '0;
    return {xa, go, go && w, go, go && w, !sh && redir};
  endfunction

  task automatic check(input string tag);
    logic [23:0] exp_v, act_v;
    #5;
    exp_v = expect_out(m_mode, m_seg, shadow_sw, mreq, rd, wr, addr);
    act_v = {xram_addr, xram_cs, xram_we, int_rd_dis, mreq_block, a15_force};
    n_chk++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s: mode=%0d seg=%0d sh=%0b addr=%h rd=%0b wr=%0b actual=%h expected=%h",
               tag, m_mode, m_seg, shadow_sw, addr, rd, wr, act_v, exp_v);
    end
  endtask

  task automatic idle();
    mreq = 0; iorq = 0; rd = 0; wr = 0; addr = '0; data = '0;
  endtask

  // I/O write; model follows R2/R3
  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    idle(); iorq = 1; wr = 1; addr = a; data = d;
    @(posedge clk);
    if (a[15:14] == 2'b01 && d[7:6] == 2'b11) begin
      m_seg = d[5:3]; m_mode = d[2:0];
    end
    @(negedge clk);
    idle();
  endtask

  task automatic mem(input logic r, input logic w, input logic [15:0] a, input string tag);
    @(negedge clk);
    idle(); mreq = 1; rd = r; wr = w; addr = a;
    check(tag);
  endtask

  function automatic string tag_for(input logic sh, input logic [2:0] mode, input logic w);
    if (sh) return "R10";
    if (mode == 3'd3) return "R6";
    if (mode == 3'd0) return "R9";
    return w ? "R8" : "R5/R7";
  endfunction

  initial begin
    void'($urandom(32'h5EED1234));
    m_seg = 0; m_mode = 0;
    shadow_sw = 0;
    idle();
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1: reset state, every window internal
    for (int w = 0; w < 4; w++) mem(1, 0, 16'(w * 16'h4000 + 16'h0123), "R1");
    for (int w = 0; w < 4; w++) mem(0, 1, 16'(w * 16'h4000 + 16'h0456), "R1");

    // R11: no request, or request without strobe
    io_write(16'h7F00, 8'hC2);
    @(negedge clk); idle(); addr = 16'hC000; rd = 1; check("R11");
    @(negedge clk); idle(); mreq = 1; addr = 16'h4000; check("R11");

    // R3: wrong port, wrong prefix, then memory shows old config (mode 2)
    io_write(16'hBF00, 8'hC5);
    mem(1, 0, 16'hC111, "R3");
    io_write(16'h7F00, 8'h85);
    mem(0, 1, 16'h4222, "R3");
    io_write(16'h3F00, 8'hFF);
    mem(1, 0, 16'h0333, "R3");

    // R12: 0xC3 vs 0xD3 place window 3 in different segments
    io_write(16'h7F00, 8'hC3);
    mem(1, 0, 16'hC040, "R12");
    io_write(16'h7F00, 8'hD3);
    mem(1, 0, 16'hC040, "R12");
    // R2: config takes effect the very next cycle
    io_write(16'h7F00, 8'hFC);
    mem(1, 0, 16'h4ABC, "R2");

    // R4..R10: full sweep of switch, segment, mode, window and direction
    for (int sh = 0; sh < 2; sh++) begin
      shadow_sw = sh[0];
      for (int s = 0; s < 8; s++)
        for (int m = 0; m < 8; m++) begin
          io_write(16'h7F00, {2'b11, s[2:0], m[2:0]});
          for (int w = 0; w < 4; w++)
            for (int d = 0; d < 2; d++)
              mem(d == 0, d == 1, {w[1:0], 14'($urandom)},
                  tag_for(sh[0], m[2:0], d == 1));
        end
    end

    // random mix: R2/R3/R4 under mixed stimulus
    shadow_sw = 0;
    for (int i = 0; i < 1500; i++) begin
      int k;
      k = int'($urandom % 4);
      if (k == 0) begin
        if (($urandom % 2) == 1) shadow_sw = ~shadow_sw;
        io_write(16'($urandom), 8'($urandom) | (($urandom % 2) == 1 ? 8'hC0 : 8'h00));
      end else begin
        logic r;
        r = 1'($urandom);
        mem(r, !r, 16'($urandom), "R4");
      end
    end

    @(negedge clk); idle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule